// File: doc/BRIEF.md
# Cross-Thread Dependence Order Enforcer

This block sits in front of one monitoring thread when many per-thread event logs are processed in parallel. Records from the local log stream arrive one at a time. A record may carry a dependence arc naming a source thread and a record ID within that thread. The block holds such a record at the head of the stream until the named thread has published progress at or beyond that ID. Records without an arc go straight through. One instance runs per monitoring thread. Each instance reads the published counters of all threads and drives its own counter.

Progress is published late on purpose. Released records are numbered from 1 upward. The downstream handler reports each finished record with a completion pulse. The published ID moves up only when a flush pulse confirms that local accelerator state has been written back. A released record can be flagged as a conflicting event, such as a free or a system-call boundary. That raises a one-cycle broadcast pulse towards the other threads. A broadcast received from another thread stops all releases until software acknowledges it.

Top module: `dep_order_enforcer`

## Requirements
- R1: After reset the published ID is 0, no alert is pending, `alert_out` is low, and the first released record gets ID 1.
- R2: A record without an arc is offered on `out_valid` in the same cycle it is presented, when no alert is pending, whatever the peer counters hold.
- R3: A record with arc (t, i), where t is not the local thread, is offered only while the published counter of thread t (bits t*32 up to t*32+31 of `peer_pub`) is at least i. It is offered in the first cycle that condition holds.
- R4: An arc whose source thread equals the local thread ID is treated as satisfied, whatever its record ID.
- R5: Each record accepted (`out_valid` and `out_ready` both high) takes the ID on `out_rid`. The next record's ID is one higher.
- R6: A completion pulse counts only while some released record is still incomplete. A pulse with nothing outstanding is ignored.
- R7: `pub_rid` changes only on the cycle after a flush pulse. It then equals the completion count held before that cycle, so a completion in the same cycle as the flush is not included.
- R8: An `alert_in` bit from another thread makes `alert_pending` high from the next cycle. While it is high, `out_valid` stays low. The bit of the local thread is ignored.
- R9: `alert_ack` clears the pending alert on the next cycle, unless a new alert from another thread arrives in the same cycle. In that case the alert stays pending.
- R10: Accepting a record flagged as conflicting drives `alert_out` high for exactly the next cycle.
- R11: `in_ready` is high exactly when a record is accepted (`out_valid` and `out_ready`). A held record stays at the input unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Head record present |
| in_ready | output | 1 | Head record consumed this cycle |
| in_data | input | 16 | Record payload |
| in_has_arc | input | 1 | Record carries a dependence arc |
| in_src_tid | input | 3 | Arc source thread |
| in_src_rid | input | 32 | Arc source record ID |
| in_conflict | input | 1 | Record is a conflicting event to broadcast |
| peer_pub | input | 256 | Published IDs of all threads, thread k in bits k*32 upward |
| out_valid | output | 1 | Record released |
| out_ready | input | 1 | Downstream accepts |
| out_data | output | 16 | Released payload |
| out_rid | output | 32 | Local ID of the released record |
| done_pulse | input | 1 | Downstream finished one released record |
| flush_pulse | input | 1 | Accelerator state flushed |
| pub_rid | output | 32 | This thread's published ID |
| alert_in | input | 8 | Conflict broadcasts, one bit per thread |
| alert_ack | input | 1 | Acknowledge pending alert |
| alert_pending | output | 1 | Alert received and not yet acknowledged |
| alert_out | output | 1 | Broadcast pulse for a released conflicting record |

## Verification
The hardest cases to reach are the edges of the arc comparison and the races on the alert flag. In the first, a peer counter sits exactly one below the required ID and then reaches it. In the second, an acknowledgement and a new alert arrive together, and a completion pulse lands in the same cycle as a flush. Directed steps set up each of these exactly. A seeded random phase then keeps peer counters close to the arc IDs, so that many records fall on either side of the threshold while alerts, completions and flushes arrive at random.

// File: rtl/dep_order_pkg.sv
package dep_order_pkg;
    parameter int RID_W  = 32;
    parameter int DATA_W = 16;

    typedef enum logic [1:0] {
        GATE_IDLE,
        GATE_OPEN,
        GATE_ARC_WAIT,
        GATE_ALERT_HOLD
    } gate_e;

    typedef struct packed {
        logic             has_arc;
        logic             conflict;
        logic [RID_W-1:0] src_rid;
    } rec_tag_t;

    function automatic logic id_reached(input logic [RID_W-1:0] have,
                                        input logic [RID_W-1:0] need);
        return have >= need;
    endfunction
endpackage

// File: rtl/doe_arc_check.sv
module doe_arc_check
    import dep_order_pkg::*;
#(
    parameter int N_THREADS = 8,
    parameter int TID_W     = $clog2(N_THREADS),
    parameter int SELF_ID   = 0
) (
    input  logic                       has_arc,
    input  logic [TID_W-1:0]           src_tid,
    input  logic [RID_W-1:0]           src_rid,
    input  logic [N_THREADS*RID_W-1:0] peer_pub,
    output logic                       satisfied
);
    logic [RID_W-1:0] peer_arr [N_THREADS];
    logic [RID_W-1:0] sel_pub;
    logic             sel_hit;

    for (genvar g = 0; g < N_THREADS; g++) begin : g_split
        assign peer_arr[g] = peer_pub[g*RID_W +: RID_W];
    end

    always_comb begin
        sel_pub = '0;
        sel_hit = 1'b0;
        for (int k = 0; k < N_THREADS; k++) begin
            if (int'(src_tid) == k) begin
                sel_pub = peer_arr[k];
                sel_hit = 1'b1;
            end
        end
    end

    always_comb begin
        if (!has_arc)
            satisfied = 1'b1;
        else if (int'(src_tid) == SELF_ID)
            satisfied = 1'b1;
        else
            satisfied = sel_hit && id_reached(sel_pub, src_rid);
    end
endmodule

// File: rtl/doe_alert_track.sv
module doe_alert_track #(
    parameter int N_THREADS = 8,
    parameter int SELF_ID   = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_THREADS-1:0] alert_in,
    input  logic                 alert_ack,
    output logic                 pending
);
    logic [N_THREADS-1:0] foreign_mask;
    logic                 any_foreign;

    for (genvar g = 0; g < N_THREADS; g++) begin : g_mask
        assign foreign_mask[g] = (g != SELF_ID);
    end

    assign any_foreign = |(alert_in & foreign_mask);

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else
            pending <= (pending && !alert_ack) || any_foreign;
    end
endmodule

// File: rtl/doe_progress.sv
module doe_progress
    import dep_order_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             done_pulse,
    input  logic             flush_pulse,
    output logic [RID_W-1:0] next_rid,
    output logic [RID_W-1:0] pub_rid
);
    logic [RID_W-1:0] rel_cnt;
    logic [RID_W-1:0] done_cnt;
    logic             outstanding;

    assign outstanding = (done_cnt != rel_cnt);
    assign next_rid    = rel_cnt + RID_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_cnt  <= '0;
            done_cnt <= '0;
            pub_rid  <= '0;
        end else begin
            if (fire)
                rel_cnt <= rel_cnt + RID_W'(1);
            if (done_pulse && outstanding)
                done_cnt <= done_cnt + RID_W'(1);
            if (flush_pulse)
                pub_rid <= done_cnt;
        end
    end
endmodule

// File: rtl/dep_order_enforcer.sv
module dep_order_enforcer
    import dep_order_pkg::*;
#(
    parameter int N_THREADS = 8,
    parameter int TID_W     = $clog2(N_THREADS),
    parameter int SELF_ID   = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [DATA_W-1:0]          in_data,
    input  logic                       in_has_arc,
    input  logic [TID_W-1:0]           in_src_tid,
    input  logic [RID_W-1:0]           in_src_rid,
    input  logic                       in_conflict,
    input  logic [N_THREADS*RID_W-1:0] peer_pub,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [DATA_W-1:0]          out_data,
    output logic [RID_W-1:0]           out_rid,
    input  logic                       done_pulse,
    input  logic                       flush_pulse,
    output logic [RID_W-1:0]           pub_rid,
    input  logic [N_THREADS-1:0]       alert_in,
    input  logic                       alert_ack,
    output logic                       alert_pending,
    output logic                       alert_out
);
    rec_tag_t tag;
    gate_e    gate;
    logic     arc_ok;
    logic     fire;

    assign tag = '{has_arc: in_has_arc, conflict: in_conflict, src_rid: in_src_rid};

    doe_arc_check #(.N_THREADS(N_THREADS), .TID_W(TID_W), .SELF_ID(SELF_ID)) u_arc (
        .has_arc   (tag.has_arc),
        .src_tid   (in_src_tid),
        .src_rid   (tag.src_rid),
        .peer_pub  (peer_pub),
        .satisfied (arc_ok)
    );

    doe_alert_track #(.N_THREADS(N_THREADS), .SELF_ID(SELF_ID)) u_alert (
        .clk       (clk),
        .rst       (rst),
        .alert_in  (alert_in),
        .alert_ack (alert_ack),
        .pending   (alert_pending)
    );

    always_comb begin
        if (!in_valid)
            gate = GATE_IDLE;
        else if (alert_pending)
            gate = GATE_ALERT_HOLD;
        else if (!arc_ok)
            gate = GATE_ARC_WAIT;
        else
            gate = GATE_OPEN;
    end

    assign out_valid = (gate == GATE_OPEN);
    assign fire      = out_valid && out_ready;
    assign in_ready  = fire;
    assign out_data  = in_data;

    doe_progress u_prog (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .done_pulse  (done_pulse),
        .flush_pulse (flush_pulse),
        .next_rid    (out_rid),
        .pub_rid     (pub_rid)
    );

    always_ff @(posedge clk) begin
        if (rst)
            alert_out <= 1'b0;
        else
            alert_out <= fire && tag.conflict;
    end
endmodule

// File: rtl/doe_checker.sv
module doe_checker
    import dep_order_pkg::*;
#(
    parameter int N_THREADS = 8,
    parameter int TID_W     = $clog2(N_THREADS),
    parameter int SELF_ID   = 0
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_ready,
    input logic                       in_has_arc,
    input logic [TID_W-1:0]           in_src_tid,
    input logic [RID_W-1:0]           in_src_rid,
    input logic                       in_conflict,
    input logic [N_THREADS*RID_W-1:0] peer_pub,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [RID_W-1:0]           out_rid,
    input logic                       flush_pulse,
    input logic [RID_W-1:0]           pub_rid,
    input logic                       alert_pending,
    input logic                       alert_out
);
    logic [RID_W-1:0] chk_pub;
    logic             foreign_arc;

    always_comb begin
        chk_pub = '0;
        for (int k = 0; k < N_THREADS; k++)
            if (int'(in_src_tid) == k) chk_pub = peer_pub[k*RID_W +: RID_W];
    end
    assign foreign_arc = in_has_arc && (int'(in_src_tid) != SELF_ID);

    assert_arc_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && foreign_arc) |-> (chk_pub >= in_src_rid));

    assert_rid_step_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (out_rid == $past(out_rid) + 1));

    assert_pub_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !flush_pulse |=> $stable(pub_rid));

    assert_alert_block_R8: assert property (@(posedge clk) disable iff (rst)
        alert_pending |-> !out_valid);

    assert_bcast_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && in_conflict) |=> alert_out);

    assert_consume_R11: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (out_valid && out_ready));
endmodule

bind dep_order_enforcer doe_checker #(
    .N_THREADS(N_THREADS), .TID_W(TID_W), .SELF_ID(SELF_ID)
) u_doe_checker (
    .clk           (clk),
    .rst           (rst),
    .in_ready      (in_ready),
    .in_has_arc    (in_has_arc),
    .in_src_tid    (in_src_tid),
    .in_src_rid    (in_src_rid),
    .in_conflict   (in_conflict),
    .peer_pub      (peer_pub),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_rid       (out_rid),
    .flush_pulse   (flush_pulse),
    .pub_rid       (pub_rid),
    .alert_pending (alert_pending),
    .alert_out     (alert_out)
);

// File: tb/dep_order_enforcer_tb.sv
module dep_order_enforcer_tb;
    localparam int N  = 8;
    localparam int TW = 3;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready, in_has_arc, in_conflict;
    logic [15:0] in_data, out_data;
    logic [TW-1:0] in_src_tid;
    logic [31:0] in_src_rid, out_rid, pub_rid;
    logic [N*32-1:0] peer_pub;
    logic out_valid, out_ready, done_pulse, flush_pulse;
    logic [N-1:0] alert_in;
    logic alert_ack, alert_pending, alert_out;

    logic [31:0] peer [N];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model state
    bit          m_pend;
    bit          m_aout;
    logic [31:0] m_rel, m_done, m_pub;

    always #10 clk = ~clk;

    always_comb
        for (int k = 0; k < N; k++) peer_pub[k*32 +: 32] = peer[k];

    dep_order_enforcer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_has_arc(in_has_arc), .in_src_tid(in_src_tid),
        .in_src_rid(in_src_rid), .in_conflict(in_conflict), .peer_pub(peer_pub),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_rid(out_rid), .done_pulse(done_pulse), .flush_pulse(flush_pulse),
        .pub_rid(pub_rid), .alert_in(alert_in), .alert_ack(alert_ack),
        .alert_pending(alert_pending), .alert_out(alert_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_valid();
        bit ok;
        ok = !in_has_arc || (int'(in_src_tid) == 0) || (peer[in_src_tid] >= in_src_rid);
        return in_valid && !m_pend && ok;
    endfunction

    task automatic idle_inputs();
        in_valid = 0; in_has_arc = 0; in_conflict = 0; in_src_tid = '0;
        in_src_rid = '0; in_data = '0; out_ready = 1; done_pulse = 0;
        flush_pulse = 0; alert_in = '0; alert_ack = 0;
    endtask

    // inputs are already set (after a negedge); check, then advance one cycle
    task automatic step();
        bit ev, fire;
        #1;
        ev = exp_valid();
        fire = ev && out_ready;
        check("R2/R3 out_valid", {31'b0, out_valid}, {31'b0, ev});
        check("R11 in_ready", {31'b0, in_ready}, {31'b0, fire});
        check("R5 out_rid", out_rid, m_rel + 1);
        check("R7 pub_rid", pub_rid, m_pub);
        check("R8 alert_pending", {31'b0, alert_pending}, {31'b0, m_pend});
        check("R10 alert_out", {31'b0, alert_out}, {31'b0, m_aout});
        if (ev) check("R2 out_data", {16'b0, out_data}, {16'b0, in_data});
        @(posedge clk);
        m_aout = fire && in_conflict;
        if (flush_pulse) m_pub = m_done;
        if (done_pulse && m_done != m_rel) m_done = m_done + 1;
        if (fire) m_rel = m_rel + 1;
        m_pend = (m_pend && !alert_ack) || (|(alert_in & 8'hFE));
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7177));
        for (int k = 0; k < N; k++) peer[k] = '0;
        idle_inputs();
        rst = 1;
        m_pend = 0; m_aout = 0; m_rel = 0; m_done = 0; m_pub = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        #1;
        check("R1 pub_rid", pub_rid, 0);
        check("R1 alert_pending", {31'b0, alert_pending}, 0);
        check("R1 alert_out", {31'b0, alert_out}, 0);
        check("R1 first rid", out_rid, 1);
        @(negedge clk);

        // R2: plain record passes
        in_valid = 1; in_data = 16'hA5A5;
        #1; check("R2 plain pass", {31'b0, out_valid}, 1);
        step();

        // R3: arc to thread 3 id 10, peer at 9 then 10
        in_has_arc = 1; in_src_tid = 3; in_src_rid = 10; peer[3] = 9;
        #1; check("R3 held below", {31'b0, out_valid}, 0);
        step(); step();
        peer[3] = 10;
        #1; check("R3 release at equal", {31'b0, out_valid}, 1);
        step();

        // R4: self arc with huge id
        in_src_tid = 0; in_src_rid = 32'hFFFF_FFF0;
        #1; check("R4 self arc", {31'b0, out_valid}, 1);
        step();
        in_has_arc = 0;

        // R6 / R7: released 3 so far; 5 completions, only 3 count
        in_valid = 0;
        done_pulse = 1;
        repeat (5) step();
        done_pulse = 1; flush_pulse = 1;
        step();
        done_pulse = 0; flush_pulse = 0;
        #1; check("R6 R7 pub after flush", pub_rid, 3);
        step();

        // R7: completion in same cycle as flush excluded
        in_valid = 1; step(); in_valid = 0;
        done_pulse = 1; flush_pulse = 1; step();
        done_pulse = 0; flush_pulse = 0;
        #1; check("R7 same-cycle done excluded", pub_rid, 3);
        flush_pulse = 1; step(); flush_pulse = 0;
        #1; check("R7 later flush", pub_rid, 4);

        // R8: own-thread alert ignored, foreign alert blocks
        in_valid = 1; alert_in = 8'h01; step(); alert_in = '0;
        #1; check("R8 self alert ignored", {31'b0, out_valid}, 1);
        alert_in = 8'h20; step(); alert_in = '0;
        #1; check("R8 foreign alert blocks", {31'b0, out_valid}, 0);
        step();
        // R9: ack together with new alert keeps pending
        alert_ack = 1; alert_in = 8'h04; step(); alert_in = '0;
        #1; check("R9 ack+alert stays", {31'b0, alert_pending}, 1);
        step(); alert_ack = 0;
        #1; check("R9 ack clears", {31'b0, alert_pending}, 0);

        // R10: conflict record broadcasts
        in_conflict = 1; step(); in_conflict = 0;
        #1; check("R10 alert_out pulse", {31'b0, alert_out}, 1);
        in_valid = 0; step();
        #1; check("R10 single pulse", {31'b0, alert_out}, 0);

        // R11: held record not consumed while downstream stalls
        in_valid = 1; out_ready = 0;
        #1; check("R11 stall no consume", {31'b0, in_ready}, 0);
        step(); out_ready = 1;

        // random phase
        for (int c = 0; c < 3000; c++) begin
            for (int k = 0; k < N; k++)
                if ($urandom_range(0, 3) == 0) peer[k] = peer[k] + 1;
            in_valid    = ($urandom_range(0, 4) != 0);
            in_has_arc  = ($urandom_range(0, 1) == 1);
            in_src_tid  = TW'($urandom_range(0, N - 1));
            in_src_rid  = peer[in_src_tid] + $urandom_range(0, 2) - 1;
            in_conflict = ($urandom_range(0, 7) == 0);
            in_data     = 16'($urandom);
            out_ready   = ($urandom_range(0, 3) != 0);
            done_pulse  = ($urandom_range(0, 1) == 1);
            flush_pulse = ($urandom_range(0, 3) == 0);
            alert_in    = ($urandom_range(0, 19) == 0) ? N'($urandom) : '0;
            alert_ack   = ($urandom_range(0, 2) == 0);
            step();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule